// File: doc/BRIEF.md
# Two-Dimensional Reshaping Address Generator

This block produces paired byte addresses for a transfer whose source and destination are both laid out as evenly spaced rows. The source holds rows of one fixed length whose starts are a constant stride apart. The destination has its own row length and its own stride. Each accepted beat moves one byte, so the transfer can repack, for example, many short rows into a few long ones. The bytes in the gaps between rows are never addressed.

A controller pulses `start_i` with the two bases, the two row lengths, the two strides and the total byte count. When the configuration is valid, the block presents one address pair per beat on a valid/ready handshake and pulses `done_o` after the last pair is taken. When the configuration is invalid, it raises a one-cycle error flag and does not start. The bus masters that use these addresses and any data storage sit outside the block.

Top module: `box_addr_gen`

## Requirements
- R1: After reset, `valid_o`, `done_o` and `cfg_err_o` are low.
- R2: The first address pair of a transfer equals the source base and the destination base sampled with the accepted start pulse.
- R3: Within a row, each accepted beat raises that side's address by exactly one byte.
- R4: After the beat that takes the last byte of a source row, the source address becomes the start of that row plus the source stride.
- R5: The destination side follows the R4 rule with its own row length and stride, and it wraps independently of the source side.
- R6: While `valid_o` is high and `ready_i` is low, `valid_o`, `src_addr_o` and `dst_addr_o` hold their values into the next cycle.
- R7: Exactly as many beats as the total byte count are accepted. `done_o` is high for one cycle, in the cycle after the last beat is accepted, and `valid_o` is low in that cycle.
- R8: A start whose source or destination stride is not greater than its row length, whose row length is zero, or whose total count is zero raises `cfg_err_o` for the one cycle after the start and produces no beats.
- R9: A start pulse while a transfer is running is ignored. The running transfer keeps its own configuration and its beat count.
- R10: Four 16-byte source rows at a 32-byte stride, moved as 64 bytes into 32-byte destination rows at a 128-byte stride, read offsets 0–15, 32–47, 64–79 and 96–111 and write offsets 0–31 and 128–159.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| src_base_i | input | 32 | Source start address |
| dst_base_i | input | 32 | Destination start address |
| src_row_len_i | input | 16 | Bytes per source row |
| src_stride_i | input | 32 | Source row start-to-start distance |
| dst_row_len_i | input | 16 | Bytes per destination row |
| dst_stride_i | input | 32 | Destination row start-to-start distance |
| total_len_i | input | 32 | Bytes to move |
| src_addr_o | output | 32 | Source byte address of the current beat |
| dst_addr_o | output | 32 | Destination byte address of the current beat |
| valid_o | output | 1 | Address pair is presented |
| ready_i | input | 1 | Consumer takes the pair |
| done_o | output | 1 | One-cycle pulse after the last beat |
| cfg_err_o | output | 1 | One-cycle pulse on a rejected start |

## Verification
Checked on every cycle: the addresses and valid hold under backpressure, the in-row column stays below the row length, and the address rises by one inside a row. Also checked on every cycle: a done pulse follows an accepted beat with valid low, an error pulse never coincides with a running transfer, and the remaining count does not move when a start arrives mid-transfer. Only the bench scenarios show that the complete address sequences match the reshaping formula. These scenarios cover the stated 16-to-32-byte example, misaligned row lengths, single-byte rows, random backpressure, the exact beat count, and the rejected configurations.

// File: rtl/box_pkg.sv
package box_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned CNT_W  = 32;

  typedef enum logic {ST_IDLE, ST_RUN} box_state_e;
endpackage

// File: rtl/box_row_walker.sv
module box_row_walker #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] row_len_i,
  input  logic [AW-1:0] stride_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] row_start_q, addr_q, stride_q;
  logic [LW-1:0] len_q, col_q;
  logic          row_end;

  assign row_end = (col_q == len_q - 1'b1);
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_start_q <= '0;
      addr_q      <= '0;
      stride_q    <= '0;
      len_q       <= '0;
      col_q       <= '0;
    end else if (load_i) begin
      row_start_q <= base_i;
      addr_q      <= base_i;
      stride_q    <= stride_i;
      len_q       <= row_len_i;
      col_q       <= '0;
    end else if (step_i) begin
      if (row_end) begin
        // skip the gap: next row begins one stride after this row's start
        row_start_q <= row_start_q + stride_q;
        addr_q      <= row_start_q + stride_q;
        col_q       <= '0;
      end else begin
        addr_q <= addr_q + 1'b1;
        col_q  <= col_q + 1'b1;
      end
    end
  end

  a_r3_col_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != '0) |-> (col_q < len_q));

  a_r3_step_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !row_end) |=> (addr_q == $past(addr_q) + 1'b1));

  a_r4_wrap_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && row_end) |=> (col_q == '0));
endmodule

// File: rtl/box_ctrl.sv
module box_ctrl
  import box_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] src_row_len_i,
  input  logic [AW-1:0] src_stride_i,
  input  logic [LW-1:0] dst_row_len_i,
  input  logic [AW-1:0] dst_stride_i,
  input  logic [CW-1:0] total_len_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          load_o,
  output logic          step_o,
  output logic          done_o,
  output logic          cfg_err_o
);
  localparam int unsigned PAD_W = AW - LW;

  box_state_e    state_q;
  logic [CW-1:0] rem_q;
  logic          done_q, err_q, cfg_bad, beat, idle_start;

  assign cfg_bad = (src_row_len_i == '0) || (dst_row_len_i == '0) || (total_len_i == '0)
                || (src_stride_i <= {{PAD_W{1'b0}}, src_row_len_i})
                || (dst_stride_i <= {{PAD_W{1'b0}}, dst_row_len_i});

  assign valid_o    = (state_q == ST_RUN);
  assign beat       = valid_o && ready_i;
  assign idle_start = (state_q == ST_IDLE) && start_i;
  assign load_o     = idle_start && !cfg_bad;
  assign step_o     = beat;
  assign done_o     = done_q;
  assign cfg_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (idle_start) begin
        if (cfg_bad) begin
          err_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          rem_q   <= total_len_i;
        end
      end else if (beat) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CW'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  a_r6_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o);

  a_r7_done_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(beat) && !valid_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_err_not_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !valid_o);

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_i && !beat) |=> $stable(rem_q));
endmodule

// File: rtl/box_addr_gen.sv
module box_addr_gen
  import box_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = LEN_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [LW-1:0] src_row_len_i,
  input  logic [AW-1:0] src_stride_i,
  input  logic [LW-1:0] dst_row_len_i,
  input  logic [AW-1:0] dst_stride_i,
  input  logic [CW-1:0] total_len_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic          done_o,
  output logic          cfg_err_o
);
  logic load, step;

  box_ctrl #(.AW(AW), .LW(LW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .src_row_len_i, .src_stride_i, .dst_row_len_i, .dst_stride_i, .total_len_i,
    .ready_i, .valid_o,
    .load_o(load), .step_o(step), .done_o, .cfg_err_o
  );

  box_row_walker #(.AW(AW), .LW(LW)) u_src (
    .clk_i, .rst_ni, .load_i(load), .step_i(step),
    .base_i(src_base_i), .row_len_i(src_row_len_i), .stride_i(src_stride_i),
    .addr_o(src_addr_o)
  );

  box_row_walker #(.AW(AW), .LW(LW)) u_dst (
    .clk_i, .rst_ni, .load_i(load), .step_i(step),
    .base_i(dst_base_i), .row_len_i(dst_row_len_i), .stride_i(dst_stride_i),
    .addr_o(dst_addr_o)
  );

  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> ($stable(src_addr_o) && $stable(dst_addr_o)));

  a_r2_load_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (src_addr_o == $past(src_base_i) && dst_addr_o == $past(dst_base_i)));
endmodule

// File: tb/tb_box_addr_gen.sv
module tb_box_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0, src_stride = '0, dst_stride = '0, total = '0;
  logic [15:0] src_len = '0, dst_len = '0;
  logic [31:0] src_addr, dst_addr;
  logic        valid, done, cfg_err;
  logic        ready_r = 1'b0;

  int n_chk = 0, n_fail = 0, n_done = 0;
  logic [63:0] exp_q[$];
  bit exp_done = 0, bp_en = 0, hold_chk = 0;
  logic [31:0] hold_src, hold_dst;

  always #5 clk = ~clk;

  box_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_base_i(src_base), .dst_base_i(dst_base),
    .src_row_len_i(src_len), .src_stride_i(src_stride),
    .dst_row_len_i(dst_len), .dst_stride_i(dst_stride),
    .total_len_i(total),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr),
    .valid_o(valid), .ready_i(ready_r),
    .done_o(done), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (exp_done) begin
      chk(done === 1'b1, "R7 done pulse after last beat", {63'd0, done}, 64'd1);
      chk(valid === 1'b0, "R7 valid low with done", {63'd0, valid}, 64'd0);
      exp_done = 0;
      n_done++;
    end else if (done === 1'b1) begin
      chk(0, "R7 unexpected done", 64'd1, 64'd0);
    end
    if (hold_chk)
      chk(valid === 1'b1 && src_addr === hold_src && dst_addr === hold_dst,
          "R6 hold under backpressure", {src_addr, dst_addr}, {hold_src, hold_dst});
    ready_r = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    hold_chk = valid && !ready_r;
    hold_src = src_addr;
    hold_dst = dst_addr;
    if (valid && ready_r) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 extra beat beyond total", {src_addr, dst_addr}, 64'd0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(src_addr === e[63:32], "R2/R3/R4 source address", {32'd0, src_addr}, {32'd0, e[63:32]});
        chk(dst_addr === e[31:0], "R2/R3/R5 destination address", {32'd0, dst_addr}, {32'd0, e[31:0]});
        if (exp_q.size() == 0) exp_done = 1;
      end
    end
  end

  task automatic run_xfer(input logic [31:0] sb, input logic [15:0] sl, input logic [31:0] ss,
                          input logic [31:0] db, input logic [15:0] dl, input logic [31:0] ds,
                          input logic [31:0] tot, input bit bp, input bit restart);
    int prev;
    for (int i = 0; i < int'(tot); i++) begin
      logic [31:0] sa, da;
      sa = sb + (32'(i) / 32'(sl)) * ss + (32'(i) % 32'(sl));
      da = db + (32'(i) / 32'(dl)) * ds + (32'(i) % 32'(dl));
      exp_q.push_back({sa, da});
    end
    prev = n_done;
    bp_en = bp;
    @(negedge clk);
    src_base = sb; src_len = sl; src_stride = ss;
    dst_base = db; dst_len = dl; dst_stride = ds; total = tot;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      // R9: a second start with another configuration while running
      repeat (3) @(negedge clk);
      src_base = 32'hDEAD_0000; dst_base = 32'hBEEF_0000; total = 32'd5;
      src_len = 16'd2; src_stride = 32'd9; dst_len = 16'd2; dst_stride = 32'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_done == prev + 1);
    @(negedge clk);
    chk(exp_q.size() == 0, "R7 all beats consumed", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic bad_cfg(input logic [15:0] sl, input logic [31:0] ss,
                         input logic [15:0] dl, input logic [31:0] ds, input logic [31:0] tot);
    @(negedge clk);
    src_len = sl; src_stride = ss; dst_len = dl; dst_stride = ds; total = tot;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err === 1'b1, "R8 error flag raised", {63'd0, cfg_err}, 64'd1);
    chk(valid === 1'b0, "R8 no start", {63'd0, valid}, 64'd0);
    @(negedge clk);
    chk(cfg_err === 1'b0, "R8 error is one cycle", {63'd0, cfg_err}, 64'd0);
    repeat (3) begin
      @(negedge clk);
      chk(valid === 1'b0, "R8 no beats after reject", {63'd0, valid}, 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(valid === 1'b0 && done === 1'b0 && cfg_err === 1'b0, "R1 outputs low in reset",
        {61'd0, valid, done, cfg_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && done === 1'b0 && cfg_err === 1'b0, "R1 outputs low after reset",
        {61'd0, valid, done, cfg_err}, 64'd0);
    // R10 stated example, full throughput then with backpressure
    run_xfer(32'h0000_1000, 16'd16, 32'd32, 32'h0000_8000, 16'd32, 32'd128, 32'd64, 0, 0);
    run_xfer(32'h0000_1000, 16'd16, 32'd32, 32'h0000_8000, 16'd32, 32'd128, 32'd64, 1, 0);
    // R5 misaligned row boundaries
    run_xfer(32'h0001_0003, 16'd5, 32'd7, 32'h0002_0000, 16'd3, 32'd10, 32'd23, 1, 0);
    // single-byte rows on the source side
    run_xfer(32'h0000_0100, 16'd1, 32'd4, 32'h0000_0200, 16'd6, 32'd8, 32'd13, 0, 0);
    // R9 restart ignored while busy
    run_xfer(32'h0003_0000, 16'd4, 32'd16, 32'h0004_0000, 16'd7, 32'd9, 32'd20, 1, 1);
    // R8 rejected configurations
    bad_cfg(16'd8, 32'd8, 16'd4, 32'd16, 32'd10);
    bad_cfg(16'd4, 32'd16, 16'd6, 32'd3, 32'd10);
    bad_cfg(16'd4, 32'd16, 16'd4, 32'd16, 32'd0);
    bad_cfg(16'd0, 32'd16, 16'd4, 32'd16, 32'd5);
    // valid run still works after rejects
    run_xfer(32'h0000_0000, 16'd3, 32'd5, 32'h0000_1000, 16'd2, 32'd3, 32'd11, 1, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule